// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the bus-master end of a 16-bit asynchronous processor bus. A core hands it one request at a time over a simple valid/acknowledge interface: a word or byte read, a word or byte write, or a request to pulse the external reset line. The sequencer turns each request into a strobed bus cycle and returns read data or an error flag with a single-cycle acknowledge.

The sequencer is clocked at twice the processor clock, so every state step lasts one half-cycle. A transfer opens with an address phase of fixed length. If the slave has not yet acknowledged by the end of that phase, the sequencer adds wait phases. It then runs a fixed data phase with the data strobes asserted, and ends with an idle gap. Byte accesses select a lane from bit 0 of the byte address, with even addresses on the upper lane. On a byte write, the lane that is not selected keeps the value last driven. All bus outputs are registered and all strobes are active-low.

Top module: `cpu_bus_seq`

## Requirements
- R1: An accepted transfer asserts `bus_as_n` for exactly ADDR_HC (5) half-cycles with both data strobes high when `bus_dtack_n` is low at the end of that phase.
- R2: While `bus_dtack_n` stays high at the end of a phase, wait phases of WAIT_HC (2) half-cycles are added. During them `bus_as_n` stays low and both data strobes stay high.
- R3: The data phase lasts DATA_HC (3) half-cycles with the data strobe(s) low. `bus_din` is sampled in its last half-cycle and returned on `rsp_rdata` with `rsp_ack`, which is high for exactly one cycle.
- R4: A word access (`req_byte`=0) drives both strobes low. A byte access with address bit 0 = 0 drives only `bus_uds_n` low and returns `bus_din[15:8]` in `rsp_rdata[7:0]`. A byte access with bit 0 = 1 drives only `bus_lds_n` low and returns `bus_din[7:0]`. The upper byte of `rsp_rdata` is zero for byte reads.
- R5: A write (`req_op`=1) holds `bus_rw` low and `bus_doe` high throughout the cycle. A word write drives `req_wdata` on `bus_dout`. A byte write places `req_wdata[7:0]` in the selected lane and leaves the other lane of `bus_dout` unchanged. A read holds `bus_rw` high and `bus_doe` low.
- R6: `bus_addr` equals `req_addr[23:1]`. Bits 31:24 and bit 0 do not reach it.
- R7: `bus_fc` equals `req_fc`, and `bus_fc` and `bus_addr` hold steady for as long as `bus_as_n` is low.
- R8: `req_op` = 2 or 3 drives `bus_rst_n` low for RST_HC (8) half-cycles with no address strobe, then acknowledges.
- R9: A low `bus_berr_n` during a wait phase ends the cycle after the current half-cycle, with no data strobe, and sets `rsp_err` with the acknowledge. Normal cycles return `rsp_err`=0.
- R10: After each acknowledge, all strobes stay negated for IDLE_HC (4) gap half-cycles. A pending request then starts its address strobe IDLE_HC+1 half-cycles after the acknowledge.
- R11: Under reset, all strobes and `bus_rst_n` are high, `bus_rw` is high and `rsp_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two edges per processor clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 reset pulse |
| req_byte | input | 1 | 1 = byte access, 0 = word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data, byte writes use bits 7:0 |
| req_fc | input | 3 | Function code for the cycle |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Cycle ended by bus error |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | 23 | Word address |
| bus_as_n | output | 1 | Address strobe |
| bus_uds_n | output | 1 | Upper data strobe |
| bus_lds_n | output | 1 | Lower data strobe |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_fc | output | 3 | Function code lines |
| bus_dout | output | 16 | Write data bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data bus |
| bus_dtack_n | input | 1 | Slave transfer acknowledge |
| bus_berr_n | input | 1 | Bus error |
| bus_rst_n | output | 1 | External reset output |

## Verification
On every cycle, the assertions check the following: data strobes appear only under the address strobe, and never in its first half-cycle; only one strobe is active on byte cycles; address and function code hold steady while the strobe is low; the reset pulse never overlaps a strobe; the acknowledge is a single pulse; and a bus error in a wait phase leads straight to the response. Only the bench's scenarios can show the exact phase lengths, how the number of wait phases follows the slave's acknowledge timing, the returned data lane, the merge of the untouched write lane, address truncation, the reset pulse length and the idle gap before the next cycle.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_RESP,
        ST_RSTP,
        ST_GAP
    } seq_st_e;

    typedef struct packed {
        logic [22:0] waddr;
        logic        lo_lane;
        logic        byte_sz;
        logic        wr;
        logic [2:0]  fc;
        logic [15:0] wdata;
    } bus_req_t;

    function automatic logic on_bus(seq_st_e s);
        return (s == ST_ADDR) || (s == ST_WAIT) || (s == ST_DATA);
    endfunction

    // {upper, lower} active-high lane selects
    function automatic logic [1:0] lane_sel(logic byte_sz, logic lo);
        if (!byte_sz) return 2'b11;
        return lo ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/cbs_fsm.sv
module cbs_fsm
    import cbs_pkg::*;
#(
    parameter int ADDR_HC = 5,
    parameter int WAIT_HC = 2,
    parameter int DATA_HC = 3,
    parameter int IDLE_HC = 4,
    parameter int RST_HC  = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_rst,
    input  logic    dtack_n,
    input  logic    berr_n,
    output seq_st_e st,
    output seq_st_e nxt,
    output logic    sample,
    output logic    abort
);
    localparam int M1 = (ADDR_HC > WAIT_HC) ? ADDR_HC : WAIT_HC;
    localparam int M2 = (DATA_HC > IDLE_HC) ? DATA_HC : IDLE_HC;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int MAXHC = (M3 > RST_HC) ? M3 : RST_HC;
    localparam int CW = $clog2(MAXHC + 1);

    logic [CW-1:0] cnt, cnt_nxt;

    assign sample = (st == ST_DATA) && (cnt == CW'(DATA_HC - 1));
    assign abort  = (st == ST_WAIT) && !berr_n;

    always_comb begin
        nxt     = st;
        cnt_nxt = cnt + 1'b1;
        case (st)
            ST_READY: begin
                cnt_nxt = '0;
                if (start) nxt = start_rst ? ST_RSTP : ST_ADDR;
            end
            ST_ADDR: if (cnt == CW'(ADDR_HC - 1)) begin
                cnt_nxt = '0;
                nxt = dtack_n ? ST_WAIT : ST_DATA;
            end
            ST_WAIT: begin
                if (!berr_n) begin
                    cnt_nxt = '0;
                    nxt = ST_RESP;
                end else if (cnt == CW'(WAIT_HC - 1)) begin
                    cnt_nxt = '0;
                    nxt = dtack_n ? ST_WAIT : ST_DATA;
                end
            end
            ST_DATA: if (cnt == CW'(DATA_HC - 1)) begin
                cnt_nxt = '0;
                nxt = ST_RESP;
            end
            ST_RESP: begin
                cnt_nxt = '0;
                nxt = ST_GAP;
            end
            ST_RSTP: if (cnt == CW'(RST_HC - 1)) begin
                cnt_nxt = '0;
                nxt = ST_RESP;
            end
            ST_GAP: if (cnt == CW'(IDLE_HC - 1)) begin
                cnt_nxt = '0;
                nxt = ST_READY;
            end
            default: begin
                cnt_nxt = '0;
                nxt = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_READY;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_nxt;
        end
    end

    // R9: a bus error seen in a wait phase goes straight to the response
    a_r9_berr_ends: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !berr_n) |=> (st == ST_RESP));

    // R2: a wait phase never opens the data phase while the slave is silent
    a_r2_no_data_without_dtack: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ADDR || st == ST_WAIT) && dtack_n) |=> (st != ST_DATA));

endmodule

// File: rtl/cbs_lane.sv
module cbs_lane
    import cbs_pkg::*;
(
    input  logic        byte_sz,
    input  logic        lo,
    input  logic [15:0] old_dout,
    input  logic [15:0] wdata,
    input  logic [15:0] din,
    output logic [1:0]  sel,
    output logic [15:0] merged,
    output logic [15:0] rd_lane
);
    assign sel = lane_sel(byte_sz, lo);

    always_comb begin
        if (!byte_sz) begin
            merged  = wdata;
            rd_lane = din;
        end else if (lo) begin
            merged  = {old_dout[15:8], wdata[7:0]};
            rd_lane = {8'h00, din[7:0]};
        end else begin
            merged  = {wdata[7:0], old_dout[7:0]};
            rd_lane = {8'h00, din[15:8]};
        end
    end
endmodule

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
    import cbs_pkg::*;
#(
    parameter int ADDR_HC = 5,
    parameter int WAIT_HC = 2,
    parameter int DATA_HC = 3,
    parameter int IDLE_HC = 4,
    parameter int RST_HC  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic        req_byte,
    input  logic [31:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [2:0]  req_fc,
    output logic        rsp_ack,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic [22:0] bus_addr,
    output logic        bus_as_n,
    output logic        bus_uds_n,
    output logic        bus_lds_n,
    output logic        bus_rw,
    output logic [2:0]  bus_fc,
    output logic [15:0] bus_dout,
    output logic        bus_doe,
    input  logic [15:0] bus_din,
    input  logic        bus_dtack_n,
    input  logic        bus_berr_n,
    output logic        bus_rst_n
);
    seq_st_e    st, nxt;
    logic       sample, abort;
    bus_req_t   rq;
    logic       fresh;
    logic       accept, cyc_wr;
    logic [1:0] sel;
    logic [15:0] merged, rd_lane;
    logic       unused_hi;

    assign unused_hi = ^{req_addr[31:24], req_op[0] & req_op[1]};
    assign accept    = (st == ST_READY) && req_valid;
    assign cyc_wr    = accept ? (req_op == 2'd1) : rq.wr;

    cbs_fsm #(
        .ADDR_HC(ADDR_HC), .WAIT_HC(WAIT_HC), .DATA_HC(DATA_HC),
        .IDLE_HC(IDLE_HC), .RST_HC(RST_HC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (req_valid),
        .start_rst(req_op[1]),
        .dtack_n  (bus_dtack_n),
        .berr_n   (bus_berr_n),
        .st       (st),
        .nxt      (nxt),
        .sample   (sample),
        .abort    (abort)
    );

    cbs_lane u_lane (
        .byte_sz (rq.byte_sz),
        .lo      (rq.lo_lane),
        .old_dout(bus_dout),
        .wdata   (rq.wdata),
        .din     (bus_din),
        .sel     (sel),
        .merged  (merged),
        .rd_lane (rd_lane)
    );

    assign bus_addr = rq.waddr;
    assign bus_fc   = rq.fc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq        <= '0;
            fresh     <= 1'b0;
            bus_dout  <= '0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            rsp_ack   <= 1'b0;
            bus_as_n  <= 1'b1;
            bus_uds_n <= 1'b1;
            bus_lds_n <= 1'b1;
            bus_rw    <= 1'b1;
            bus_doe   <= 1'b0;
            bus_rst_n <= 1'b1;
        end else begin
            fresh <= accept && (req_op == 2'd1);
            if (accept) begin
                rq.waddr   <= req_addr[23:1];
                rq.lo_lane <= req_addr[0];
                rq.byte_sz <= req_byte;
                rq.wr      <= (req_op == 2'd1);
                rq.fc      <= req_fc;
                rq.wdata   <= req_wdata;
                rsp_err    <= 1'b0;
                rsp_rdata  <= '0;
            end
            if (fresh) bus_dout <= merged;
            if (sample && !rq.wr) rsp_rdata <= rd_lane;
            if (abort) rsp_err <= 1'b1;
            rsp_ack   <= (nxt == ST_RESP);
            bus_as_n  <= !on_bus(nxt);
            bus_uds_n <= !((nxt == ST_DATA) && sel[1]);
            bus_lds_n <= !((nxt == ST_DATA) && sel[0]);
            bus_rw    <= !(on_bus(nxt) && cyc_wr);
            bus_doe   <= on_bus(nxt) && cyc_wr;
            bus_rst_n <= !(nxt == ST_RSTP);
        end
    end

    // R3: data strobes only under the address strobe
    a_r3_ds_under_as: assert property (@(posedge clk) disable iff (rst)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    // R1: the first half-cycle of an address strobe carries no data strobe
    a_r1_as_leads_ds: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> (bus_uds_n && bus_lds_n));

    // R4: a byte cycle never drives both strobes
    a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (rq.byte_sz && !bus_as_n) |-> (bus_uds_n || bus_lds_n));

    // R7: address and function code steady while strobed
    a_r7_steady: assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_fc) && $stable(bus_addr)));

    // R8: reset pulse and address strobe never overlap
    a_r8_rst_no_as: assert property (@(posedge clk) disable iff (rst)
        !bus_rst_n |-> bus_as_n);

    // R3: acknowledge is a single-cycle pulse
    a_r3_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_ack |=> !rsp_ack);

endmodule

// File: tb/cpu_bus_seq_bench.sv
module cpu_bus_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_byte = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_fc = '0;
    logic        rsp_ack, rsp_err;
    logic [15:0] rsp_rdata;
    logic [22:0] bus_addr;
    logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, bus_rst_n;
    logic [2:0]  bus_fc;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_dtack_n = 1'b1;
    logic        bus_berr_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model_dout = '0;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_bus_seq u_cpu_bus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_fc(req_fc), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
        .bus_fc(bus_fc), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n),
        .bus_rst_n(bus_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cycle(input logic [1:0] op, input logic bsz,
                            input logic [31:0] a, input logic [15:0] wd,
                            input logic [2:0] fc, input int waits,
                            input logic [15:0] din, input int berr_after,
                            input bit chk_gap);
        int pre = 0, ao = 0, ds = 0, rl = 0, guard = 0;
        int target = 5 + 2 * waits;
        int berr_at = (berr_after > 0) ? 5 + berr_after : -1;
        bit seen = 0, bad_ds = 0, bad_addr = 0, bad_fc = 0, bad_rw = 0;
        bit bad_doe = 0, bad_dout = 0, got = 0;
        logic [1:0]  exp_ds;
        logic [15:0] exp_rd;
        logic [15:0] got_rd = '0;
        logic        got_err = 1'b0;
        logic        lo = a[0];
        logic        is_wr = (op == 2'd1);

        exp_ds = !bsz ? 2'b00 : (lo ? 2'b10 : 2'b01);
        exp_rd = !bsz ? din : (lo ? {8'h00, din[7:0]} : {8'h00, din[15:8]});
        if (is_wr && berr_after == 0)
            model_dout = !bsz ? wd : (lo ? {model_dout[15:8], wd[7:0]}
                                         : {wd[7:0], model_dout[7:0]});
        else if (is_wr)
            model_dout = !bsz ? wd : (lo ? {model_dout[15:8], wd[7:0]}
                                         : {wd[7:0], model_dout[7:0]});

        req_valid = 1'b1; req_op = op; req_byte = bsz; req_addr = a;
        req_wdata = wd; req_fc = fc; bus_din = din;
        while (!got && guard < 200) begin
            @(negedge clk);
            guard++;
            if (rsp_ack) begin
                got = 1; got_rd = rsp_rdata; got_err = rsp_err;
            end else begin
                if (!bus_as_n) begin
                    seen = 1; req_valid = 1'b0;
                    if (bus_addr != a[23:1]) bad_addr = 1;
                    if (bus_fc != fc) bad_fc = 1;
                    if (bus_rw != !is_wr) bad_rw = 1;
                    if (bus_doe != is_wr) bad_doe = 1;
                    if (bus_uds_n && bus_lds_n) ao++;
                    else begin
                        ds++;
                        if ({bus_uds_n, bus_lds_n} != exp_ds) bad_ds = 1;
                        if (is_wr && bus_dout != model_dout) bad_dout = 1;
                    end
                end else if (!bus_rst_n) begin
                    rl++; req_valid = 1'b0;
                end else if (!seen) pre++;
                bus_dtack_n = !(ao >= target);
                bus_berr_n  = !(berr_at > 0 && ao >= berr_at);
            end
        end
        bus_dtack_n = 1'b1; bus_berr_n = 1'b1; req_valid = 1'b0;
        chk(got, "watch ack", 32'(got), 1);
        if (chk_gap) chk(pre == 5, "R10 gap before strobe", pre, 5);
        if (op[1]) begin
            chk(rl == 8, "R8 reset pulse length", rl, 8);
            chk(!seen, "R8 no strobe in reset op", 32'(seen), 0);
        end else if (berr_after > 0) begin
            chk(ao == 5 + berr_after, "R9 abort point", ao, 5 + berr_after);
            chk(ds == 0, "R9 no data strobe", ds, 0);
            chk(got_err == 1'b1, "R9 error flag", 32'(got_err), 1);
        end else begin
            if (waits == 0) chk(ao == 5, "R1 address phase", ao, 5);
            else chk(ao == target, "R2 wait phases", ao, target);
            chk(ds == 3, "R3 data phase length", ds, 3);
            chk(!bad_ds, "R4 strobe lanes", 32'(bad_ds), 0);
            chk(!bad_addr, "R6 word address", 32'(bad_addr), 0);
            chk(!bad_fc, "R7 function code", 32'(bad_fc), 0);
            chk(!bad_rw && !bad_doe, "R5 direction", {bad_rw, bad_doe}, 0);
            chk(got_err == 1'b0, "R9 no error", 32'(got_err), 0);
            if (is_wr) chk(!bad_dout, "R5 write lane merge", 32'(bad_dout), 0);
            else chk(got_rd == exp_rd, "R3 R4 read data", got_rd, exp_rd);
        end
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_rst_n} == 5'b11111,
            "R11 strobes idle",
            {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_rst_n}, 5'b11111);
        chk(rsp_ack == 1'b0 && bus_doe == 1'b0, "R11 ack low",
            {rsp_ack, bus_doe}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 32; i++) begin
            logic [1:0]  op  = 2'(i[4]);
            logic        bsz = i[3];
            logic [31:0] a   = {8'h5A, 24'(i * 24'h013579)} & 32'hFFFF_FFFE;
            a[0] = i[2];
            do_cycle(op, bsz, a, 16'hA000 + 16'(i * 16'h0111), 3'(i),
                     i % 4, 16'h1E00 + 16'(i * 16'h0F0D), 0, i > 0);
        end
        // R6: high byte of the request address is dropped
        do_cycle(2'd0, 1'b0, 32'hAB12_3457, 16'h0, 3'd5, 1, 16'hBEEF, 0, 1);
        // R5: consecutive byte writes fill both lanes
        do_cycle(2'd1, 1'b1, 32'h0000_0100, 16'h00C3, 3'd1, 0, 16'h0, 0, 1);
        do_cycle(2'd1, 1'b1, 32'h0000_0101, 16'h003C, 3'd1, 0, 16'h0, 0, 1);
        chk(bus_dout == 16'hC33C, "R5 both lanes kept", bus_dout, 16'hC33C);
        // R9: bus error at different points of the wait
        for (int j = 1; j <= 3; j++)
            do_cycle(2'd0, 1'b0, 32'h0000_2000 + 32'(j * 2), 16'h0, 3'd2, 10,
                     16'h1234, j, 1);
        // R9 then a normal cycle clears the error
        do_cycle(2'd0, 1'b1, 32'h0000_0301, 16'h0, 3'd6, 2, 16'h77A5, 0, 1);
        // R8: reset op, with both reset encodings
        do_cycle(2'd2, 1'b0, 32'h0, 16'h0, 3'd0, 0, 16'h0, 0, 1);
        do_cycle(2'd3, 1'b0, 32'h0, 16'h0, 3'd0, 0, 16'h0, 0, 1);
        do_cycle(2'd1, 1'b0, 32'h00FF_FFFE, 16'h5AA5, 3'd7, 3, 16'h0, 0, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule